// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Dual Address Framing

This block is a slave on a two-wire serial bus. It holds a small bank of 8-bit control registers. It samples the bus clock and data lines on the system clock and finds the bus events (START, repeated START, STOP) and the clock edges. It then runs one byte engine that answers two device addresses.

The address that matches selects the framing for the whole transaction:

- **Pointer framing.** A master may write a register pointer and then read or write data from that register onward. The pointer advances after each byte and wraps at the end of the bank.
- **Block framing.** Access always begins at register 0. A write needs an all-zero command code and then a byte count, which the block acknowledges and ignores. A read sends a count byte before the register data.

The register contents are always visible as one flat parallel output. A surrounding chip uses this output to switch clock outputs on and off. The data line is driven only through an open-drain style pull-low enable.

Top module: `twowire_ctrl_slave`

## Requirements
- R1: After reset every register reads 8'hFF on `regs_o` (register i at bits [8i+7:8i]) and `sda_oe_o` is low, leaving the data line released.
- R2: The pointer-framing address is 7'b1011x00: bit 2 is ignored, so both 7'h58 and 7'h5C are acknowledged. The block-framing address is 7'h69. Any other address is not acknowledged, and later bytes are neither acknowledged nor written until the next START.
- R3: In a pointer-framing write, the first byte after the address loads the register pointer. Each later byte is written to the register the pointer selects, and the pointer then advances by one.
- R4: A written register takes its new value while the slave acknowledges that byte, before any STOP. At most one register changes per system clock cycle, and registers change only through the byte engine's write strobe.
- R5: The pointer wraps from the last register to register 0. A pointer byte equal to or larger than the number of registers selects register 0.
- R6: A STOP or a repeated START that arrives before the eighth bit of a data byte discards that partial byte, and no register changes.
- R7: A pointer-framing read (pointer written, repeated START, address with R/W=1) returns bytes MSB first. It starts at the pointed register and advances the pointer after each byte. A master NACK ends the transfer and releases the data line.
- R8: A block-framing write sets the pointer to 0. A command code of 0x00 is acknowledged. Any other command code is not acknowledged, and the transaction is dropped. The byte after the command code is acknowledged and changes no register. Later bytes fill the registers from register 0 upward, with wrap.
- R9: A block-framing read (address+W, command 0x00, repeated START, address+R) first returns a count byte equal to the number of registers (3), then register 0 upward.
- R10: The slave acknowledges by pulling the data line low for the ninth clock. It changes `sda_oe_o` only while the bus clock is low, except to release at START or STOP.
- R11: After a STOP the data line is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe_o | output | 1 | High pulls the data line low; low releases it |
| regs_o | output | NREG*DW (24) | All control registers, register i at bits [8i+7:8i] |

## Verification
The bench builds the block with its default values: three registers, two synchronizer stages, and the addresses 7'h69 and 7'b1011x00. With three registers, a write of four bytes is enough to reach the pointer wrap. A pointer byte of 7 reaches the out-of-range case. The count byte of a block read is a known 3. The bus quarter period is eight system clocks, against a detection latency of three. This lets the bench sample register values in the middle of the ninth clock and watch every data line change relative to the clock line.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK,
    S_TX,
    S_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    P_ADDR,
    P_FIRST,
    P_COUNT,
    P_DATA
  } rx_phase_t;

  typedef enum logic {
    M_PTR,
    M_BLOCK
  } frame_mode_t;
endpackage

// File: rtl/dwr_bus_sync.sv
module dwr_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_ff[STAGES-1];
      sda_d <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock is held high are bus events
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dwr_reg_bank.sv
module dwr_reg_bank #(
  parameter int              NREG    = 3,
  parameter int              DW      = 8,
  parameter logic [DW-1:0]   RST_VAL = '1,
  localparam int             IW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [IW-1:0]        rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic [NREG*DW-1:0]   regs_flat
);
  logic [DW-1:0] bank [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          bank[i] <= RST_VAL;
        end else if (wr_en && (wr_idx == IW'(i))) begin
          bank[i] <= wr_data;
        end
      end
      assign regs_flat[i*DW +: DW] = bank[i];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == IW'(k)) rd_data = bank[k];
    end
  end
endmodule

// File: rtl/dwr_link_engine.sv
module dwr_link_engine
  import dwr_pkg::*;
#(
  parameter int          NREG        = 3,
  parameter int          DW          = 8,
  parameter logic [6:0]  BLK_ADDR    = 7'h69,
  parameter logic [6:0]  PTR_ADDR    = 7'h58,
  parameter logic [6:0]  PTR_DC_MASK = 7'h04,
  localparam int         IW          = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int         CW          = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scl_rise,
  input  logic           scl_fall,
  input  logic           sda_s,
  input  logic           start_det,
  input  logic           stop_det,
  input  logic [DW-1:0]  rd_data,
  output logic           sda_oe,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [DW-1:0]  wr_data,
  output logic [IW-1:0]  ptr
);
  localparam logic [DW-1:0] NREG_B = DW'(NREG);
  localparam logic [CW-1:0] FULL   = CW'(DW);

  bus_state_t  state;
  rx_phase_t   phase;
  frame_mode_t mode;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic [DW-1:0] txsh;
  logic          to_tx;
  logic          count_pend;
  logic          mack;

  logic          hit_blk;
  logic          hit_ptr;
  logic [IW-1:0] ld_ptr;
  logic [DW-1:0] tx_byte;

  function automatic logic [IW-1:0] ptr_next(input logic [IW-1:0] p);
    return (p == IW'(NREG - 1)) ? '0 : p + 1'b1;
  endfunction

  assign hit_blk = (shreg[DW-1:DW-7] == BLK_ADDR);
  assign hit_ptr = (((shreg[DW-1:DW-7] ^ PTR_ADDR) & ~PTR_DC_MASK) == 7'd0);
  assign ld_ptr  = (shreg < NREG_B) ? shreg[IW-1:0] : '0;
  assign tx_byte = count_pend ? NREG_B : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      phase      <= P_ADDR;
      mode       <= M_PTR;
      cnt        <= '0;
      shreg      <= '0;
      txsh       <= '0;
      to_tx      <= 1'b0;
      count_pend <= 1'b0;
      mack       <= 1'b0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      ptr        <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state  <= S_RX;
        phase  <= P_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_RX: begin
            if (scl_rise && (cnt != FULL)) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && (cnt == FULL)) begin
              cnt <= '0;
              unique case (phase)
                P_ADDR: begin
                  if (hit_blk || hit_ptr) begin
                    mode   <= hit_blk ? M_BLOCK : M_PTR;
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                    if (hit_blk) ptr <= '0;
                    if (shreg[0]) begin
                      to_tx      <= 1'b1;
                      count_pend <= hit_blk;
                    end else begin
                      to_tx <= 1'b0;
                      phase <= P_FIRST;
                    end
                  end else begin
                    state <= S_IDLE;
                  end
                end
                P_FIRST: begin
                  if (mode == M_PTR) begin
                    ptr    <= ld_ptr;
                    phase  <= P_DATA;
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                  end else if (shreg == '0) begin
                    ptr    <= '0;
                    phase  <= P_COUNT;
                    sda_oe <= 1'b1;
                    state  <= S_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                P_COUNT: begin
                  phase  <= P_DATA;
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end
                P_DATA: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr_next(ptr);
                  sda_oe  <= 1'b1;
                  state   <= S_ACK;
                end
                default: state <= S_IDLE;
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (to_tx) begin
                txsh   <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
                if (count_pend) count_pend <= 1'b0;
                else            ptr        <= ptr_next(ptr);
                state  <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise && (cnt != FULL)) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                state  <= S_MACK;
              end else begin
                txsh   <= {txsh[DW-2:0], 1'b0};
                sda_oe <= ~txsh[DW-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                txsh   <= tx_byte;
                sda_oe <= ~tx_byte[DW-1];
                if (count_pend) count_pend <= 1'b0;
                else            ptr        <= ptr_next(ptr);
                state  <= S_TX;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twowire_ctrl_slave.sv
module twowire_ctrl_slave #(
  parameter int          NREG        = 3,
  parameter int          DW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [6:0]  BLK_ADDR    = 7'h69,
  parameter logic [6:0]  PTR_ADDR    = 7'h58,
  parameter logic [6:0]  PTR_DC_MASK = 7'h04,
  parameter logic [7:0]  RST_VAL     = 8'hFF,
  localparam int         IW          = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  output logic [NREG*DW-1:0]  regs_o
);
  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic          bank_wr;
  logic [IW-1:0] bank_wr_idx;
  logic [DW-1:0] bank_wr_data;
  logic [IW-1:0] bank_ptr;
  logic [DW-1:0] bank_rd_data;

  dwr_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dwr_link_engine #(
    .NREG        (NREG),
    .DW          (DW),
    .BLK_ADDR    (BLK_ADDR),
    .PTR_ADDR    (PTR_ADDR),
    .PTR_DC_MASK (PTR_DC_MASK)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (bank_rd_data),
    .sda_oe    (sda_oe_o),
    .wr_en     (bank_wr),
    .wr_idx    (bank_wr_idx),
    .wr_data   (bank_wr_data),
    .ptr       (bank_ptr)
  );

  dwr_reg_bank #(
    .NREG    (NREG),
    .DW      (DW),
    .RST_VAL (DW'(RST_VAL))
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bank_wr),
    .wr_idx    (bank_wr_idx),
    .wr_data   (bank_wr_data),
    .rd_idx    (bank_ptr),
    .rd_data   (bank_rd_data),
    .regs_flat (regs_o)
  );
endmodule

// File: rtl/dwr_checker.sv
module dwr_checker #(
  parameter int         NREG    = 3,
  parameter int         DW      = 8,
  parameter logic [7:0] RST_VAL = 8'hFF
) (
  input logic               clk,
  input logic               rst,
  input logic               scl_s,
  input logic               start_det,
  input logic               stop_det,
  input logic               sda_oe,
  input logic               wr_en,
  input logic [NREG*DW-1:0] regs
);
  logic               past_valid = 1'b0;
  logic [NREG*DW-1:0] regs_q;
  logic [NREG-1:0]    chg;

  always_ff @(posedge clk) begin
    past_valid <= 1'b1;
    regs_q     <= regs;
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_chg
      assign chg[i] = past_valid && (regs_q[i*DW +: DW] != regs[i*DW +: DW]);
    end
  endgenerate

  // R1: reset leaves all registers at their reset byte and the line released
  a_r1_reset_state: assert property (@(posedge clk)
    (past_valid && $past(rst)) |-> ((regs == {NREG{DW'(RST_VAL)}}) && !sda_oe));

  // R10: the data line moves only while the bus clock is low, bar START/STOP
  a_r10_sda_low_phase: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $changed(sda_oe) && !$past(start_det) && !$past(stop_det))
      |-> !$past(scl_s));

  // R4: registers change only after the engine's write strobe
  a_r4_write_by_strobe: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $changed(regs)) |-> $past(wr_en));

  // R4: one register at a time
  a_r4_one_reg_per_cycle: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chg));

  // R11: a STOP releases the data line
  a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
    (past_valid && $past(stop_det)) |-> !sda_oe);
endmodule

bind twowire_ctrl_slave dwr_checker #(
  .NREG    (NREG),
  .DW      (DW),
  .RST_VAL (RST_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe_o),
  .wr_en     (bank_wr),
  .regs      (regs_o)
);

// File: tb/twowire_ctrl_slave_tb_top.sv
`timescale 1ns/1ps
module twowire_ctrl_slave_tb_top;
  localparam int Q    = 8;
  localparam int NREG = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [23:0] regs;
  wire         sda_line = sda_m & ~sda_oe;

  logic [7:0]  mdl [NREG];
  int          checks = 0;
  int          errors = 0;
  int          viol = 0;
  logic        oe_q = 1'b0;
  logic        scl_q = 1'b1;

  always #4 clk = ~clk;

  twowire_ctrl_slave dut_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe_o (sda_oe),
    .regs_o   (regs)
  );

  // R10 monitor: slave line changes must fall in clock-low time
  always @(negedge clk) begin
    if (!rst && (sda_oe !== oe_q) && (scl_m || scl_q)) viol++;
    oe_q  <= sda_oe;
    scl_q <= scl_m;
  end

  function automatic logic [23:0] mdl_flat();
    return {mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q();
    end
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack, output logic [23:0] snap);
    put_bits(b, 8);
    sda_m = 1'b1; q(); scl_m = 1'b1;
    repeat (Q/2) @(negedge clk);
    ack  = ~sda_line;
    snap = regs;
    repeat (Q/2) @(negedge clk);
    scl_m = 1'b0; q();
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_line; scl_m = 1'b0;
    end
    q(); sda_m = ~mack; q(); scl_m = 1'b1; q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  // pointer-framing write with model update
  task automatic ptr_write(input logic [7:0] adr8, input logic [7:0] pb, input logic [7:0] d [4], input int n, input string tag);
    logic ack; logic [23:0] snap; int p;
    p = (pb < NREG) ? int'(pb) : 0;
    bus_start();
    put_byte(adr8, ack, snap); chk(ack, {tag, " R2 address ack"}, ack, 1);
    put_byte(pb, ack, snap);   chk(ack, {tag, " R3 pointer ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      mdl[p] = d[k];
      p = (p + 1) % NREG;
      put_byte(d[k], ack, snap);
      chk(ack && snap == mdl_flat(), {tag, " R4 value at ack"}, {7'd0, ack, snap}, {8'd1, mdl_flat()});
    end
    bus_stop();
    chk(regs == mdl_flat(), {tag, " R3 regs after stop"}, regs, mdl_flat());
  endtask

  task automatic t_reset();
    chk(regs == 24'hFFFFFF, "R1 reset regs", regs, 24'hFFFFFF);
    chk(sda_oe == 1'b0, "R1 reset line released", sda_oe, 0);
  endtask

  task automatic t_ptr_write();
    logic [7:0] d [4];
    d = '{8'h12, 8'h34, 8'h00, 8'h00};
    ptr_write(8'hB0, 8'd1, d, 2, "R3 base address");
  endtask

  task automatic t_wrap();
    logic [7:0] d [4];
    d = '{8'hAA, 8'hBB, 8'hCC, 8'h00};
    ptr_write(8'hB8, 8'd2, d, 3, "R5 wrap alt address");
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    ptr_write(8'hB0, 8'd7, d, 1, "R5 pointer out of range");
  endtask

  task automatic t_ptr_read();
    logic ack; logic [23:0] snap; logic [7:0] b; int p;
    p = 1;
    bus_start();
    put_byte(8'hB0, ack, snap);
    put_byte(8'd1, ack, snap);
    bus_start();
    put_byte(8'hB1, ack, snap); chk(ack, "R7 read address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      chk(b == mdl[p], "R7 read byte", b, mdl[p]);
      p = (p + 1) % NREG;
    end
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
  endtask

  task automatic t_miss();
    logic ack; logic [23:0] snap;
    bus_start();
    put_byte(8'hA0, ack, snap); chk(!ack, "R2 foreign address nack", ack, 0);
    put_byte(8'h00, ack, snap); chk(!ack, "R2 later byte nack", ack, 0);
    put_byte(8'h11, ack, snap); chk(!ack, "R2 data ignored nack", ack, 0);
    bus_stop();
    chk(regs == mdl_flat(), "R2 regs unchanged", regs, mdl_flat());
  endtask

  task automatic t_abort();
    logic ack; logic [23:0] snap;
    bus_start();
    put_byte(8'hB0, ack, snap);
    put_byte(8'd0, ack, snap);
    put_bits(8'h00, 4);
    bus_stop();
    chk(regs == mdl_flat(), "R6 stop mid byte", regs, mdl_flat());
    bus_start();
    put_byte(8'hB0, ack, snap);
    put_byte(8'd1, ack, snap);
    put_bits(8'h00, 5);
    bus_start();
    bus_stop();
    chk(regs == mdl_flat(), "R6 restart mid byte", regs, mdl_flat());
  endtask

  task automatic t_blk_write();
    logic ack; logic [23:0] snap; logic [7:0] d [3];
    d = '{8'h11, 8'h22, 8'h33};
    bus_start();
    put_byte(8'hD2, ack, snap); chk(ack, "R2 block address ack", ack, 1);
    put_byte(8'h00, ack, snap); chk(ack, "R8 command zero ack", ack, 1);
    put_byte(8'h05, ack, snap);
    chk(ack && snap == mdl_flat(), "R8 count ignored", {7'd0, ack, snap}, {8'd1, mdl_flat()});
    for (int k = 0; k < 3; k++) begin
      mdl[k] = d[k];
      put_byte(d[k], ack, snap);
      chk(ack && snap == mdl_flat(), "R8 block data at ack", {7'd0, ack, snap}, {8'd1, mdl_flat()});
    end
    bus_stop();
  endtask

  task automatic t_blk_badcmd();
    logic ack; logic [23:0] snap;
    bus_start();
    put_byte(8'hD2, ack, snap);
    put_byte(8'h01, ack, snap); chk(!ack, "R8 nonzero command nack", ack, 0);
    put_byte(8'h77, ack, snap); chk(!ack, "R8 dropped byte nack", ack, 0);
    bus_stop();
    chk(regs == mdl_flat(), "R8 regs unchanged", regs, mdl_flat());
  endtask

  task automatic t_blk_read();
    logic ack; logic [23:0] snap; logic [7:0] b;
    bus_start();
    put_byte(8'hD2, ack, snap);
    put_byte(8'h00, ack, snap);
    bus_start();
    put_byte(8'hD3, ack, snap); chk(ack, "R9 read address ack", ack, 1);
    get_byte(1'b1, b); chk(b == 8'd3, "R9 count byte", b, 3);
    for (int k = 0; k < 3; k++) begin
      get_byte(k != 2, b);
      chk(b == mdl[k], "R9 block read byte", b, mdl[k]);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R11 released after stop", sda_oe, 0);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = 8'hFF;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_ptr_write();
    t_wrap();
    t_ptr_read();
    t_miss();
    t_abort();
    t_blk_write();
    t_blk_badcmd();
    t_blk_read();
    chk(viol == 0, "R10 line changed in clock high", viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule